// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block is the issue-stage gatekeeper of an in-order pipeline. The pipeline feeds four execution units that take different numbers of cycles: a single-cycle integer unit, a pipelined adder, a pipelined multiplier and a divider that is not pipelined. All of them return results through one register-file write port. Each cycle the block receives one decoded candidate: its target unit, two source registers and a destination register. It then either grants issue or holds the candidate back.

The candidate is held back if the divider is occupied, if either source is still waiting on an unfinished result, if its destination is already the target of an unfinished operation, or if the write port is already booked for the cycle its result would come back. A ring of slots, one per future cycle, records which destination will be written in each coming cycle. This ring is both the write-port booking and the table of pending destinations. The slot for the current cycle drives the writeback outputs.

A held candidate retries every cycle with unchanged inputs until it is granted.

Top module: `issue_interlock`

## Requirements
- R1: After reset no writeback is signalled (`wb_valid_o` = 0), and a first candidate presented on an empty pipeline is granted at once.
- R2: With `valid_i` high, exactly one of `issue_o` and `stall_o` is high. With `valid_i` low, both are low.
- R3: Unit encoding is 0 integer, 1 adder, 2 multiplier, 3 divider, with default latencies of 1, 4, 7 and 24 cycles. A candidate granted in cycle c appears in cycle c+latency as `wb_valid_o` = 1, with `wb_dst_o` equal to its destination.
- R4: A candidate whose result would come back in a cycle already booked for another result is stalled.
- R5: A candidate is stalled if either source equals the destination of a granted operation that writes back in a later cycle. A source matching an operation that writes back in the current cycle does not stall, because that value is bypassed.
- R6: A candidate is stalled if its destination equals the destination of any granted operation that writes back in a later cycle.
- R7: After a divide is granted in cycle c, no further divide is granted before cycle c+25.
- R8: The adder and the multiplier each accept independent operations in consecutive cycles without stalling.
- R9: A stalled candidate books nothing: it never produces a writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A decoded candidate is present |
| unit_i | input | 2 | Target unit: 0 integer, 1 adder, 2 multiplier, 3 divider |
| src1_i | input | REG_W | First source register |
| src2_i | input | REG_W | Second source register |
| dst_i | input | REG_W | Destination register |
| issue_o | output | 1 | Candidate granted this cycle |
| stall_o | output | 1 | Candidate held back this cycle |
| wb_valid_o | output | 1 | A result uses the write port this cycle |
| wb_dst_o | output | REG_W | Register written this cycle |

## Verification
The hardest cases to reach are the ones where two hazards overlap in time. One example is a write-port collision between a multiply and an add issued a few cycles apart. Another is a divide blocked for its full busy interval while other results drain. A third is a source whose producer writes back in exactly the cycle the consumer asks, which must be granted and not stalled. Directed sequences place operations at these exact cycle offsets and count how many cycles each candidate waits. Random traffic then draws registers from a small subset, so that dependences and destination clashes occur densely alongside divider and port contention.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic [1:0] {
    U_INT = 2'd0,
    U_ADD = 2'd1,
    U_MUL = 2'd2,
    U_DIV = 2'd3
  } unit_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wport_ring.sv
// Slot k holds the destination written k cycles from now.
module wport_ring #(
  parameter int REG_W = 5,
  parameter int DEPTH = 25,
  localparam int LAT_W = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         book_i,
  input  logic [LAT_W-1:0]             book_lat_i,
  input  logic [REG_W-1:0]             book_dst_i,
  output logic [DEPTH-1:0]             slot_vld_o,
  output logic [DEPTH-1:0][REG_W-1:0]  slot_dst_o
);
  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][REG_W-1:0] dst_q;

  generate
    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_slot
      logic hit;
      assign hit = book_i && (book_lat_i == LAT_W'(k + 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[k] <= 1'b0;
          dst_q[k] <= '0;
        end else begin
          vld_q[k] <= vld_q[k+1] | hit;
          dst_q[k] <= hit ? book_dst_i : dst_q[k+1];
        end
      end
    end
  endgenerate

  // top slot is never booked directly; it only empties
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q[DEPTH-1] <= 1'b0;
      dst_q[DEPTH-1] <= '0;
    end else begin
      vld_q[DEPTH-1] <= 1'b0;
      dst_q[DEPTH-1] <= '0;
    end
  end

  assign slot_vld_o = vld_q;
  assign slot_dst_o = dst_q;
endmodule

// File: rtl/div_busy.sv
module div_busy #(
  parameter int II = 25,
  localparam int CNT_W = $clog2(II + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(II - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/hazard_check.sv
module hazard_check #(
  parameter int REG_W = 5,
  parameter int DEPTH = 25,
  localparam int LAT_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            slot_vld_i,
  input  logic [DEPTH-1:0][REG_W-1:0] slot_dst_i,
  input  logic [REG_W-1:0]            src1_i,
  input  logic [REG_W-1:0]            src2_i,
  input  logic [REG_W-1:0]            dst_i,
  input  logic [LAT_W-1:0]            lat_i,
  output logic                        raw_o,
  output logic                        waw_o,
  output logic                        port_o
);
  logic [DEPTH-1:0] raw_m, waw_m, port_m;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
      logic later;
      // slot 0 writes this cycle: bypassed, and retires before any new result
      assign later     = (k != 0) && slot_vld_i[k];
      assign raw_m[k]  = later && ((slot_dst_i[k] == src1_i) || (slot_dst_i[k] == src2_i));
      assign waw_m[k]  = later && (slot_dst_i[k] == dst_i);
      assign port_m[k] = slot_vld_i[k] && (lat_i == LAT_W'(k));
    end
  endgenerate

  assign raw_o  = |raw_m;
  assign waw_o  = |waw_m;
  assign port_o = |port_m;
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import issue_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int INT_LAT = 1,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 7,
  parameter int DIV_LAT = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       unit_i,
  input  logic [REG_W-1:0] src1_i,
  input  logic [REG_W-1:0] src2_i,
  input  logic [REG_W-1:0] dst_i,
  output logic             issue_o,
  output logic             stall_o,
  output logic             wb_valid_o,
  output logic [REG_W-1:0] wb_dst_o
);
  localparam int MAX_LAT = max2(max2(INT_LAT, ADD_LAT), max2(MUL_LAT, DIV_LAT));
  localparam int DEPTH   = MAX_LAT + 1;
  localparam int LAT_W   = $clog2(DEPTH);
  localparam int DIV_II  = DIV_LAT + 1;

  unit_e                       unit;
  logic [LAT_W-1:0]            lat;
  logic [DEPTH-1:0]            slot_vld;
  logic [DEPTH-1:0][REG_W-1:0] slot_dst;
  logic                        raw, waw, port_busy, div_busy_w, struct_haz, hazard;

  assign unit = unit_e'(unit_i);

  always_comb begin
    case (unit)
      U_INT:   lat = LAT_W'(INT_LAT);
      U_ADD:   lat = LAT_W'(ADD_LAT);
      U_MUL:   lat = LAT_W'(MUL_LAT);
      default: lat = LAT_W'(DIV_LAT);
    endcase
  end

  hazard_check #(.REG_W(REG_W), .DEPTH(DEPTH)) i_hazard (
    .slot_vld_i (slot_vld),
    .slot_dst_i (slot_dst),
    .src1_i     (src1_i),
    .src2_i     (src2_i),
    .dst_i      (dst_i),
    .lat_i      (lat),
    .raw_o      (raw),
    .waw_o      (waw),
    .port_o     (port_busy)
  );

  div_busy #(.II(DIV_II)) i_div_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue_o && (unit == U_DIV)),
    .busy_o  (div_busy_w)
  );

  assign struct_haz = (unit == U_DIV) && div_busy_w;
  assign hazard     = raw | waw | port_busy | struct_haz;
  assign issue_o    = valid_i && !hazard;
  assign stall_o    = valid_i && hazard;

  wport_ring #(.REG_W(REG_W), .DEPTH(DEPTH)) i_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .book_i     (issue_o),
    .book_lat_i (lat),
    .book_dst_i (dst_i),
    .slot_vld_o (slot_vld),
    .slot_dst_o (slot_dst)
  );

  assign wb_valid_o = slot_vld[0];
  assign wb_dst_o   = slot_dst[0];
endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk #(
  parameter int REG_W   = 5,
  parameter int DIV_LAT = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       unit_i,
  input logic [REG_W-1:0] src1_i,
  input logic [REG_W-1:0] src2_i,
  input logic [REG_W-1:0] dst_i,
  input logic             issue_o,
  input logic             stall_o,
  input logic             wb_valid_o,
  input logic [REG_W-1:0] wb_dst_o
);
  localparam int II    = DIV_LAT + 1;
  localparam int GAP_W = $clog2(II + 1);

  logic             armed_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= GAP_W'(II);
    else if (issue_o && unit_i == 2'd3)   gap_q <= GAP_W'(1);
    else if (gap_q != GAP_W'(II))         gap_q <= gap_q + 1'b1;
  end

  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i ? (issue_o != stall_o) : (!issue_o && !stall_o)));

  assert_int_wb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && unit_i == 2'd0) |=> (wb_valid_o && wb_dst_o == $past(dst_i)));

  assert_raw_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(issue_o && unit_i == 2'd1) && valid_i &&
     (src1_i == $past(dst_i) || src2_i == $past(dst_i))) |-> stall_o);

  assert_waw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(issue_o && unit_i == 2'd2) && valid_i && dst_i == $past(dst_i))
    |-> stall_o);

  assert_div_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && unit_i == 2'd3) |-> (gap_q == GAP_W'(II)));
endmodule

bind issue_interlock issue_interlock_chk #(.REG_W(REG_W), .DIV_LAT(DIV_LAT)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .unit_i     (unit_i),
  .src1_i     (src1_i),
  .src2_i     (src2_i),
  .dst_i      (dst_i),
  .issue_o    (issue_o),
  .stall_o    (stall_o),
  .wb_valid_o (wb_valid_o),
  .wb_dst_o   (wb_dst_o)
);

// File: tb/test_issue_interlock.sv
`timescale 1ns/1ps
module test_issue_interlock;
  localparam int REG_W = 5;
  localparam int PER   = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic [1:0]       unit = '0;
  logic [REG_W-1:0] src1 = '0, src2 = '0, dst = '0;
  logic             issue, stall, wb_valid;
  logic [REG_W-1:0] wb_dst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_div = -1000;
  bit book_v[64];
  logic [REG_W-1:0] book_d[64];

  always #(PER/2) clk = ~clk;

  issue_interlock i_issue_interlock (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .unit_i(unit),
    .src1_i(src1), .src2_i(src2), .dst_i(dst),
    .issue_o(issue), .stall_o(stall), .wb_valid_o(wb_valid), .wb_dst_o(wb_dst)
  );

  function automatic int lat_of(input int u);
    case (u)
      0: return 1;
      1: return 4;
      2: return 7;
      default: return 24;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // one clock of stimulus; returns whether the model grants it
  task automatic step(input bit v, input int u, input int s1, input int s2, input int d,
                      output bit granted);
    bit raw, waw, port, divb, exp_iss;
    string tag;
    @(negedge clk);
    valid = v; unit = u[1:0]; src1 = s1[REG_W-1:0]; src2 = s2[REG_W-1:0]; dst = d[REG_W-1:0];
    #1;
    raw = 0; waw = 0;
    for (int k = 1; k <= 24; k++) begin
      if (book_v[(cyc+k)%64]) begin
        if (book_d[(cyc+k)%64] == src1 || book_d[(cyc+k)%64] == src2) raw = 1;
        if (book_d[(cyc+k)%64] == dst) waw = 1;
      end
    end
    port = book_v[(cyc+lat_of(u))%64];
    divb = (u == 3) && (cyc < last_div + 25);
    exp_iss = v && !(raw || waw || port || divb);
    tag = divb ? "R7" : port ? "R4" : raw ? "R5" : waw ? "R6" : "R8";
    chk(tag, int'(issue), int'(exp_iss));
    chk("R2", int'(stall), int'(v && !exp_iss));
    chk(book_v[cyc%64] ? "R3" : "R9", int'(wb_valid), int'(book_v[cyc%64]));
    if (book_v[cyc%64]) chk("R3", int'(wb_dst), int'(book_d[cyc%64]));
    book_v[cyc%64] = 0;
    if (exp_iss) begin
      book_v[(cyc+lat_of(u))%64] = 1;
      book_d[(cyc+lat_of(u))%64] = dst;
      if (u == 3) last_div = cyc;
    end
    granted = exp_iss;
    cyc++;
  endtask

  task automatic push(input int u, input int s1, input int s2, input int d, output int tries);
    bit g;
    tries = 0;
    do begin
      step(1'b1, u, s1, s2, d, g);
      tries++;
    end while (!g && tries < 60);
  endtask

  task automatic idle(input int n);
    bit g;
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, g);
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin book_v[i] = 0; book_d[i] = '0; end
    repeat (3) @(posedge clk);
    #1 chk("R1", int'(wb_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1: first candidate on empty pipeline granted at once
    push(0, 1, 2, 3, t); chk("R1", t, 1);
    idle(30);

    // R7: back-to-back divides, second waits until c+25
    push(3, 1, 2, 20, t);
    push(3, 4, 5, 21, t); chk("R7", t, 25);
    idle(30);

    // R4: mul at c, add at c+3 collides in the write port
    push(2, 1, 2, 10, t);
    idle(2);
    push(1, 3, 4, 11, t); chk("R4", t, 2);
    idle(30);

    // R5: producer writing this cycle is bypassed
    push(0, 1, 2, 12, t);
    push(0, 12, 3, 13, t); chk("R5", t, 1);
    idle(5);
    // R5: consumer waits for an add result
    push(1, 1, 2, 14, t);
    push(0, 3, 14, 15, t); chk("R5", t, 4);
    idle(30);

    // R6: same destination as in-flight mul
    push(2, 1, 2, 16, t);
    push(0, 3, 4, 16, t); chk("R6", t, 7);
    idle(30);

    // R8: pipelined units accept every cycle
    push(1, 1, 2, 17, t); chk("R8", t, 1);
    push(1, 3, 4, 18, t); chk("R8", t, 1);
    push(2, 5, 6, 19, t); chk("R8", t, 1);
    push(2, 7, 8, 22, t); chk("R8", t, 1);
    idle(30);

    // random traffic on a small register set
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 4) == 0) idle(int'($urandom_range(1, 3)));
      push(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), t);
    end
    idle(30);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule